// File: doc/BRIEF.md
# Bridge Control Register Bank

A bank of 28 word-wide control registers for a host-bridge controller. A simple word bus reaches the bank. Each cycle a master drives either a write strobe or a read strobe with a byte address and, for writes, a 32-bit data word. The bank holds configuration, address-map, GPIO, interrupt-controller, mailbox, cache and timing words. Most of them only store what is written. The hardware those words would steer lies outside this block.

Three kinds of word behave differently. The interrupt-enable word cannot be written directly. It changes only through two alias words: one that sets the bits written as one, and one that clears them. The enable word and the interrupt-status word are read-only. A write that moves the soft-reset bit of the general-configuration word from 0 to 1 makes the bank raise a one-cycle system-reset request to the rest of the chip.

Top module: `brg_ctl_regs`

## Requirements
- R1: When reset is asserted, every word takes its reset value and all other words read zero. The reset values are 0x00000C40 at offset 0x00, 0x00001384 at 0x04, 0x2BFF8010 at 0x08, 0x255E0091 at 0x0C, 0x00006140 at 0x10, 0x000001FF at 0x1C, 0x000001FF at 0x20, 0x00000008 at 0x68 and 0x10000000 at 0x6C.
- R2: The word index is addr[7:2], and addr[1:0] is ignored. A read strobe at an index from 0 to 27 returns the stored word on rdata after the next clock edge. rdata then holds until the next read. A write to any ordinary index stores all 32 bits.
- R3: A write to offset 0x30 stores the data at 0x30 and ORs it into the enable word at 0x38.
- R4: A write to offset 0x34 stores the data at 0x34 and clears each enable bit that is one in the data.
- R5: Writes to offset 0x38 (enable) and offset 0x3C (status) change nothing. The enable word resets to zero. The status word always reads zero.
- R6: sys_rst_req is high for exactly the one cycle after the clock edge that takes a write to offset 0x04 in which data bit 2 is 1 while the stored bit 2 is 0. The written word is still stored. A write with bit 2 already at 1 raises no request.
- R7: Offsets 0x70 to 0xFC hold no register. Writes there change no register, and reads there return zero.
- R8: sys_rst_req stays low after any access other than the one named in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, never high together with rd_en |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address within the bank |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| sys_rst_req | output | 1 | One-cycle system-reset request |

## Verification
The bench sets and clears enable bits through both aliases, with overlapping masks. A design that wired the aliases as plain stores, or mixed up their polarity, would return an enable word that differs from the running model. The soft-reset bit resets to one, so the bench first writes it low and then high. It also repeats the high write and writes other bits. A level-sensitive or free-running detector would pulse at the wrong time or not at all. Writes to the read-only words and to the unmapped range are each followed by a full sweep of the bank, which exposes any alias decode that corrupts a neighbour.

// File: rtl/brg_ctl_regs.sv
module brg_ctl_regs #(
  parameter int DW      = 32,
  parameter int AW      = 8,
  parameter int NREG    = 28,
  parameter int RST_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          sys_rst_req
);
  localparam int IW = AW - 2;
  localparam int SW = $clog2(NREG);
  localparam logic [IW-1:0] IX_GEN = IW'(1);
  localparam logic [IW-1:0] IX_SET = IW'(12);
  localparam logic [IW-1:0] IX_CLR = IW'(13);
  localparam logic [IW-1:0] IX_IEN = IW'(14);
  localparam logic [IW-1:0] IX_ISR = IW'(15);

  function automatic logic [DW-1:0] rst_val(input int i);
    case (i)
      0:       return DW'(32'h0000_0C40);
      1:       return DW'(32'h0000_1384);
      2:       return DW'(32'h2BFF_8010);
      3:       return DW'(32'h255E_0091);
      4:       return DW'(32'h0000_6140);
      7, 8:    return DW'(32'h0000_01FF);
      26:      return DW'(32'h0000_0008);
      27:      return DW'(32'h1000_0000);
      default: return '0;
    endcase
  endfunction

  logic [DW-1:0] regs [NREG];
  logic [IW-1:0] widx;
  logic [SW-1:0] sidx;
  logic          hit;
  logic          rise;

  assign widx = addr[AW-1:2];
  assign sidx = widx[SW-1:0];
  assign hit  = ({{(32-IW){1'b0}}, widx} < 32'(NREG));
  assign rise = wr_en && (widx == IX_GEN) && !regs[IX_GEN[SW-1:0]][RST_BIT] && wdata[RST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= rst_val(i);
      rdata       <= '0;
      sys_rst_req <= 1'b0;
    end else begin
      sys_rst_req <= rise;
      if (wr_en && hit) begin
        case (widx)
          IX_IEN, IX_ISR: ;
          IX_SET: begin
            regs[IX_SET[SW-1:0]] <= wdata;
            regs[IX_IEN[SW-1:0]] <= regs[IX_IEN[SW-1:0]] | wdata;
          end
          IX_CLR: begin
            regs[IX_CLR[SW-1:0]] <= wdata;
            regs[IX_IEN[SW-1:0]] <= regs[IX_IEN[SW-1:0]] & ~wdata;
          end
          default: regs[sidx] <= wdata;
        endcase
      end
      if (rd_en) rdata <= hit ? regs[sidx] : '0;
    end
  end

  AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == IX_SET) |=> ((regs[IX_IEN[SW-1:0]] & $past(wdata)) == $past(wdata))); // R3
  AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == IX_CLR) |=> ((regs[IX_IEN[SW-1:0]] & $past(wdata)) == '0)); // R4
  AST_RO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (widx == IX_IEN || widx == IX_ISR)) |=> $stable(regs[IX_IEN[SW-1:0]])); // R5
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req); // R6
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(wr_en && widx == IX_GEN && wdata[RST_BIT])); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (rdata == '0)); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en)); // R2
endmodule

// File: tb/tb_brg_ctl_regs.sv
module tb_brg_ctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sys_rst_req;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model [NREG];

  brg_ctl_regs dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                    .addr(addr), .wdata(wdata), .rdata(rdata), .sys_rst_req(sys_rst_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_rst(input int i);
    case (i)
      0: return 32'hC40;         1: return 32'h1384;
      2: return 32'h2BFF8010;    3: return 32'h255E0091;
      4: return 32'h6140;        7: return 32'h1FF;
      8: return 32'h1FF;         26: return 32'h8;
      27: return 32'h10000000;   default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    int ix = int'(a[7:2]);
    logic exp_req = (ix == 1) && !model[1][2] && d[2];
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    check(exp_req ? "R6" : req, {31'b0, sys_rst_req}, {31'b0, exp_req});
    if (ix < NREG) begin
      if (ix == 12) begin model[12] = d; model[14] |= d; end
      else if (ix == 13) begin model[13] = d; model[14] &= ~d; end
      else if (ix != 14 && ix != 15) model[ix] = d;
    end
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    int ix = int'(a[7:2]);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, (ix < NREG) ? model[ix] : 32'h0);
    check("R8", {31'b0, sys_rst_req}, 32'h0);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < NREG; i++) rd(8'(i*4), req);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NREG; i++) model[i] = exp_rst(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", rdata, 32'h0);
    sweep("R1");
    rd(8'h70, "R7"); rd(8'hFC, "R7");
    // R2: ordinary stores, low address bits ignored
    wr(8'h40, 32'hDEADBEEF, "R2"); rd(8'h40, "R2");
    wr(8'h4B, 32'h12345678, "R2"); rd(8'h48, "R2");
    // R3 / R4 aliases
    wr(8'h30, 32'h0000_F00F, "R3"); rd(8'h38, "R3"); rd(8'h30, "R3");
    wr(8'h30, 32'h00FF_0000, "R3"); rd(8'h38, "R3");
    wr(8'h34, 32'h0000_F0F0, "R4"); rd(8'h38, "R4"); rd(8'h34, "R4");
    // R5 read-only words
    wr(8'h38, 32'hFFFFFFFF, "R5"); wr(8'h3C, 32'hFFFFFFFF, "R5");
    sweep("R5");
    // R6 soft reset edge
    wr(8'h04, 32'h1384, "R8");
    wr(8'h04, 32'h0000, "R8");
    wr(8'h04, 32'h0004, "R6");
    rd(8'h04, "R6");
    wr(8'h04, 32'h0004, "R8");
    wr(8'h04, 32'h00FB, "R8");
    wr(8'h04, 32'hFFFF, "R6");
    // R7 unmapped writes
    wr(8'h70, 32'hA5A5A5A5, "R7"); wr(8'hF0, 32'h5A5A5A5A, "R7");
    sweep("R7"); rd(8'h74, "R7");
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [7:0] a = 8'($urandom_range(0, 31) * 4);
      logic [31:0] d = $urandom;
      if ($urandom_range(0, 3) == 0) d[2] = ~d[2];
      if ($urandom_range(0, 1) == 1) wr(a, d, "R2");
      else rd(a, (int'(a[7:2]) >= NREG) ? "R7" : "R2");
    end
    sweep("R2");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule